// File: doc/BRIEF.md
# Keyed Configuration Register Controller

This block is the configuration front end of a multi-function peripheral controller. It sits on an 8-bit host I/O bus and claims a two-byte window. The even address is an index port and the odd address is a data port. The host unlocks the block by writing a fixed key to the index port twice in a row. It then picks a register by writing its index and reads or writes that register through the data port. A separate exit key locks the block again.

Indexes below 0x30 reach a shared global bank. Global register 7 selects one of several logical devices, and that device's bank serves indexes 0x30 and up. Only some devices accept writes, and some of those refuse writes to their interrupt range. Each device drives its activate bit, its 16-bit base address and its interrupt byte as raw outputs. A per-device one-cycle strobe tells downstream decode logic when one of those fields has changed.

Top module: `cfg_keyed_regs`

## Requirements
- R1: The index port is at `BASE_ADDR` (default 0x03F0) and the data port is at `BASE_ADDR+1`. Reads of any other address return 0xFF, and writes to any other address have no effect.
- R2: Configuration mode is entered when 0x55 is written to the index port on two consecutive index-port writes. Any other value written to the index port in between restarts the count.
- R3: Writing 0xAA to the index port in configuration mode leaves configuration mode. The latched index keeps its previous value.
- R4: Outside configuration mode, reads of either port return 0xFF and data-port writes change no register.
- R5: In configuration mode, any index-port write other than 0xAA latches the index, 0x55 included. A read of the index port returns the latched index.
- R6: Indexes 0x00 to 0x2F address 48 writable global bytes. After reset, 0x03=0x03, 0x20=0x03, 0x21=0x01, 0x24=0x04, 0x26=0xF0 and 0x27=0x03, and all other global bytes are 0x00.
- R7: Global register 7 selects the device bank (0 to 9) that serves indexes 0x30 to 0xFF. With a selection of 10 or more, those indexes read 0x00 and writes are dropped.
- R8: Writes are dropped for all indexes of devices 1, 2, 6, 7, 8 and 9, and for indexes 0x70 to 0x7F of devices 0 and 3. Dropped registers read their reset value.
- R9: After reset, devices 0, 3, 4 and 5 have index 0x30 set to 0x01. Their {0x60,0x61} values are 0x03F0, 0x0378, 0x03F8 and 0x02F8, and their 0x70 values are 0x06, 0x07, 0x04 and 0x03. All other device bytes are 0x00. `dev_active` is bit 0 of index 0x30, `dev_base` is {0x60,0x61} and `dev_irq` is index 0x70, each on the device's slice.
- R10: `dev_update[d]` is high for exactly the one cycle after an accepted write that changes the value of index 0x30, 0x60, 0x61 or 0x70 of device d. A write of the same value does not raise it.
- R11: Any data-port read or write clears a pending first 0x55, so a following single 0x55 does not enter configuration mode.
- R12: Reset is asynchronous active-low and is released through two flops. After release the block is locked, the latched index is 0x00 and all registers hold their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | Host I/O address |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational from the address |
| cfg_mode | output | 1 | High while configuration mode is open |
| dev_active | output | NUM_DEV | Activate bit per device |
| dev_base | output | 16*NUM_DEV | Base address per device |
| dev_irq | output | 8*NUM_DEV | Interrupt byte per device |
| dev_update | output | NUM_DEV | One-cycle change strobe per device |

## Verification
The key logic is driven with several index-port sequences: a clean double key, a key interrupted by another value, a key split by a data-port access, and a key sent to an address outside the window. Each sequence separates a correct key counter from one that never restarts or is never cleared. The global bank is swept over all 48 bytes, first for reset values and then with a distinct address-derived pattern, which exposes aliasing between indexes. Every device selection from 0 to 12 is tried with a free-range index, an interrupt-range index and the strobe-watched indexes. This separates the writable, partly locked, fully locked and out-of-range banks, and shows same-value writes against changing writes.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

  localparam logic [7:0] KEY_ENTER = 8'h55;
  localparam logic [7:0] KEY_EXIT  = 8'hAA;

  localparam logic [7:0] IDX_ACT    = 8'h30;
  localparam logic [7:0] IDX_BASE_H = 8'h60;
  localparam logic [7:0] IDX_BASE_L = 8'h61;
  localparam logic [7:0] IDX_IRQ    = 8'h70;

  // Reset content of the global bank.
  function automatic logic [7:0] glb_rst_val(input int idx);
    case (idx)
      8'h03:   return 8'h03;
      8'h20:   return 8'h03;
      8'h21:   return 8'h01;
      8'h24:   return 8'h04;
      8'h26:   return 8'hF0;
      8'h27:   return 8'h03;
      default: return 8'h00;
    endcase
  endfunction

  // Reset content of a device bank, addressed by full index.
  function automatic logic [7:0] dev_rst_val(input int dev, input int idx);
    logic [7:0] act, bh, bl, irq;
    act = 8'h01;
    case (dev)
      0:       begin bh = 8'h03; bl = 8'hF0; irq = 8'h06; end
      3:       begin bh = 8'h03; bl = 8'h78; irq = 8'h07; end
      4:       begin bh = 8'h03; bl = 8'hF8; irq = 8'h04; end
      5:       begin bh = 8'h02; bl = 8'hF8; irq = 8'h03; end
      default: begin act = 8'h00; bh = 8'h00; bl = 8'h00; irq = 8'h00; end
    endcase
    case (idx)
      32'h30:  return act;
      32'h60:  return bh;
      32'h61:  return bl;
      32'h70:  return irq;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/cfg_key_ctl.sv
module cfg_key_ctl
  import cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic       dat_acc,
  input  logic [7:0] wdata,
  output logic       cfg_mode,
  output logic [7:0] index
);

  logic       mode_q, mode_d;
  logic       seen_q, seen_d;
  logic [7:0] idx_q, idx_d;

  always_comb begin
    mode_d = mode_q;
    seen_d = seen_q;
    idx_d  = idx_q;
    if (idx_wr) begin
      if (!mode_q) begin
        if (wdata == KEY_ENTER) begin
          if (seen_q) begin
            mode_d = 1'b1;
            seen_d = 1'b0;
          end else begin
            seen_d = 1'b1;
          end
        end else begin
          seen_d = 1'b0;
        end
      end else if (wdata == KEY_EXIT) begin
        mode_d = 1'b0;
      end else begin
        idx_d = wdata;
      end
    end else if (dat_acc) begin
      seen_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      seen_q <= 1'b0;
      idx_q  <= 8'h00;
    end else begin
      mode_q <= mode_d;
      seen_q <= seen_d;
      idx_q  <= idx_d;
    end
  end

  assign cfg_mode = mode_q;
  assign index    = idx_q;

  // R2: a second consecutive key opens configuration mode
  a_r2_double_key_enters: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_wr && !mode_q && seen_q && wdata == KEY_ENTER) |=> mode_q);

  // R3: exit key closes the mode and leaves the index alone
  a_r3_exit_keeps_index: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_wr && mode_q && wdata == KEY_EXIT) |=> (!mode_q && idx_q == $past(idx_q)));

  // R11: a data-port access drops a pending first key
  a_r11_data_clears_key: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_acc && !mode_q) |=> !seen_q);

endmodule

// File: rtl/cfg_glb_bank.sv
module cfg_glb_bank
  import cfg_pkg::*;
#(
  parameter int DEPTH = 48
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] idx,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic [7:0] dev_sel
);

  localparam int AW = $clog2(DEPTH);

  logic [7:0]    mem_q [DEPTH];
  logic [7:0]    mem_d [DEPTH];
  logic [AW-1:0] off;

  assign off = idx[AW-1:0];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
    if (wr_en) mem_d[off] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= glb_rst_val(i);
    end else begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
    end
  end

  assign rdata   = mem_q[off];
  assign dev_sel = mem_q[7];

  // R7: writing index 7 updates the device selection seen by the banks
  a_r7_select_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == 8'h07) |=> dev_sel == $past(wdata));

endmodule

// File: rtl/cfg_dev_bank.sv
module cfg_dev_bank
  import cfg_pkg::*;
#(
  parameter int DEV_ID   = 0,
  parameter bit WRITABLE = 1'b1,
  parameter bit IRQ_LOCK = 1'b0,
  parameter int LO_IDX   = 48
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  idx,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  output logic        active,
  output logic [15:0] base,
  output logic [7:0]  irq,
  output logic        update
);

  localparam int DEPTH = 256 - LO_IDX;
  localparam logic [7:0] LO = 8'(LO_IDX);

  logic [7:0] off;
  assign off = idx - LO;

  generate
    if (WRITABLE) begin : g_store
      logic [7:0] mem_q [DEPTH];
      logic [7:0] mem_d [DEPTH];
      logic       accept, watched;
      logic       upd_q, upd_d;

      assign accept  = wr_en && !(IRQ_LOCK && idx[7:4] == 4'h7);
      assign watched = (idx == IDX_ACT) || (idx == IDX_BASE_H) ||
                       (idx == IDX_BASE_L) || (idx == IDX_IRQ);

      always_comb begin
        for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
        upd_d = 1'b0;
        if (accept) begin
          mem_d[off] = wdata;
          upd_d      = watched && (wdata != mem_q[off]);
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < DEPTH; i++) mem_q[i] <= dev_rst_val(DEV_ID, i + LO_IDX);
          upd_q <= 1'b0;
        end else begin
          for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
          upd_q <= upd_d;
        end
      end

      assign rdata  = mem_q[off];
      assign active = mem_q[IDX_ACT - LO][0];
      assign base   = {mem_q[IDX_BASE_H - LO], mem_q[IDX_BASE_L - LO]};
      assign irq    = mem_q[IDX_IRQ - LO];
      assign update = upd_q;

      if (IRQ_LOCK) begin : g_lock_chk
        // R8: the interrupt range of a locked device never moves
        a_r8_irq_range_locked: assert property (@(posedge clk) disable iff (!rst_n)
          (wr_en && idx[7:4] == 4'h7) |=> (irq == $past(irq) && !update));
      end
    end else begin : g_const
      assign rdata  = dev_rst_val(DEV_ID, int'(idx));
      assign active = dev_rst_val(DEV_ID, 32'h30) != 8'h00;
      assign base   = {dev_rst_val(DEV_ID, 32'h60), dev_rst_val(DEV_ID, 32'h61)};
      assign irq    = dev_rst_val(DEV_ID, 32'h70);
      assign update = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/cfg_keyed_regs.sv
module cfg_keyed_regs
  import cfg_pkg::*;
#(
  parameter logic [15:0]        BASE_ADDR = 16'h03F0,
  parameter int                 NUM_DEV   = 10,
  parameter int                 GLB_DEPTH = 48,
  parameter logic [NUM_DEV-1:0] WR_MASK   = 10'b00_0011_1001,
  parameter logic [NUM_DEV-1:0] LOCK_MASK = 10'b00_0000_1001
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [15:0]            io_addr,
  input  logic                   io_wr,
  input  logic                   io_rd,
  input  logic [7:0]             io_wdata,
  output logic [7:0]             io_rdata,
  output logic                   cfg_mode,
  output logic [NUM_DEV-1:0]     dev_active,
  output logic [16*NUM_DEV-1:0]  dev_base,
  output logic [8*NUM_DEV-1:0]   dev_irq,
  output logic [NUM_DEV-1:0]     dev_update
);

  localparam logic [7:0] LO = 8'(GLB_DEPTH);

  // Reset: asserted at once, released after two clock edges.
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic       hit, idx_wr, dat_wr, dat_acc, dat_wr_cfg;
  logic [7:0] index, dev_sel, glb_rdata;

  assign hit        = (io_addr[15:1] == BASE_ADDR[15:1]);
  assign idx_wr     = hit && !io_addr[0] && io_wr;
  assign dat_wr     = hit &&  io_addr[0] && io_wr;
  assign dat_acc    = hit &&  io_addr[0] && (io_wr || io_rd);
  assign dat_wr_cfg = dat_wr && cfg_mode;

  cfg_key_ctl u_key (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .idx_wr   (idx_wr),
    .dat_acc  (dat_acc),
    .wdata    (io_wdata),
    .cfg_mode (cfg_mode),
    .index    (index)
  );

  cfg_glb_bank #(.DEPTH(GLB_DEPTH)) u_glb (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .wr_en   (dat_wr_cfg && index < LO),
    .idx     (index),
    .wdata   (io_wdata),
    .rdata   (glb_rdata),
    .dev_sel (dev_sel)
  );

  logic [7:0] dev_rd [NUM_DEV];

  generate
    for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
      cfg_dev_bank #(
        .DEV_ID   (d),
        .WRITABLE (WR_MASK[d]),
        .IRQ_LOCK (LOCK_MASK[d]),
        .LO_IDX   (GLB_DEPTH)
      ) u_bank (
        .clk    (clk),
        .rst_n  (rst_core_n),
        .wr_en  (dat_wr_cfg && index >= LO && dev_sel == 8'(d)),
        .idx    (index),
        .wdata  (io_wdata),
        .rdata  (dev_rd[d]),
        .active (dev_active[d]),
        .base   (dev_base[16*d +: 16]),
        .irq    (dev_irq[8*d +: 8]),
        .update (dev_update[d])
      );
    end
  endgenerate

  always_comb begin
    io_rdata = 8'hFF;
    if (hit && cfg_mode) begin
      if (!io_addr[0]) begin
        io_rdata = index;
      end else if (index < LO) begin
        io_rdata = glb_rdata;
      end else begin
        io_rdata = 8'h00;
        for (int d = 0; d < NUM_DEV; d++) begin
          if (dev_sel == 8'(d)) io_rdata = dev_rd[d];
        end
      end
    end
  end

  // R4: a data write while locked leaves every device field unchanged
  a_r4_locked_write_ignored: assert property (@(posedge clk) disable iff (!rst_core_n)
    (dat_wr && !cfg_mode) |=> (dev_base == $past(dev_base) && dev_irq == $past(dev_irq)
                               && dev_update == '0));

  // R10: one access can only change one device
  a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rst_core_n)
    $onehot0(dev_update));

  // R10: no strobe without a data write in the previous cycle
  a_r10_strobe_needs_write: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!dat_wr_cfg) |=> dev_update == '0);

endmodule

// File: tb/cfg_keyed_regs_bench.sv
module cfg_keyed_regs_bench;

  localparam int CLK_P = 10;
  localparam logic [15:0] IDXP = 16'h03F0;
  localparam logic [15:0] DATP = 16'h03F1;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [15:0]  io_addr;
  logic         io_wr, io_rd;
  logic [7:0]   io_wdata, io_rdata;
  logic         cfg_mode;
  logic [9:0]   dev_active, dev_update;
  logic [159:0] dev_base;
  logic [79:0]  dev_irq;

  int errors = 0;
  int checks = 0;

  always #(CLK_P/2) clk = ~clk;

  cfg_keyed_regs u_cfg_keyed_regs (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_mode(cfg_mode),
    .dev_active(dev_active), .dev_base(dev_base), .dev_irq(dev_irq),
    .dev_update(dev_update)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] v);
    io_addr = a; io_wdata = v; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [7:0] v);
    io_addr = a; io_rd = 1'b1;
    #1 v = io_rdata;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic reg_wr(input logic [7:0] i, input logic [7:0] v);
    bus_wr(IDXP, i);
    bus_wr(DATP, v);
  endtask

  task automatic reg_rd(input logic [7:0] i, output logic [7:0] v);
    bus_wr(IDXP, i);
    bus_rd(DATP, v);
  endtask

  function automatic logic [7:0] exp_glb(input int i);
    case (i)
      3: return 8'h03; 32: return 8'h03; 33: return 8'h01;
      36: return 8'h04; 38: return 8'hF0; 39: return 8'h03;
      default: return 8'h00;
    endcase
  endfunction

  function automatic bit wr_ok(input int d);
    return d == 0 || d == 3 || d == 4 || d == 5;
  endfunction

  function automatic bit irq_lock(input int d);
    return d == 0 || d == 3;
  endfunction

  function automatic logic [15:0] exp_base(input int d);
    case (d)
      0: return 16'h03F0; 3: return 16'h0378; 4: return 16'h03F8; 5: return 16'h02F8;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [7:0] exp_irq(input int d);
    case (d)
      0: return 8'h06; 3: return 8'h07; 4: return 8'h04; 5: return 8'h03;
      default: return 8'h00;
    endcase
  endfunction

  initial begin
    #(CLK_P*100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    io_addr = 16'h0; io_wr = 1'b0; io_rd = 1'b0; io_wdata = 8'h0; rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12 / R4: locked after reset, both ports read 0xFF
    chk("R12 cfg_mode after reset", 16'(cfg_mode), 16'h0);
    bus_rd(IDXP, v); chk("R4 index port locked", 16'(v), 16'hFF);
    bus_rd(DATP, v); chk("R4 data port locked", 16'(v), 16'hFF);

    // R9: device outputs after reset
    for (int d = 0; d < 10; d++) begin
      chk($sformatf("R9 active dev%0d", d), 16'(dev_active[d]), 16'(wr_ok(d)));
      chk($sformatf("R9 base dev%0d", d), dev_base[16*d +: 16], exp_base(d));
      chk($sformatf("R9 irq dev%0d", d), 16'(dev_irq[8*d +: 8]), 16'(exp_irq(d)));
    end

    // R1: keys outside the window do nothing
    bus_wr(16'h03F2, 8'h55); bus_wr(16'h03F2, 8'h55);
    bus_rd(IDXP, v); chk("R1 key at other address", 16'(v), 16'hFF);
    // R2: interrupted key restarts
    bus_wr(IDXP, 8'h55); bus_wr(IDXP, 8'h12); bus_wr(IDXP, 8'h55);
    bus_rd(IDXP, v); chk("R2 interrupted key", 16'(v), 16'hFF);
    // R11: data access between keys clears the pending key
    bus_rd(DATP, v); bus_wr(IDXP, 8'h55);
    bus_rd(IDXP, v); chk("R11 data access clears key", 16'(v), 16'hFF);
    // R2: clean double key enters; R12 index reset 0
    bus_wr(IDXP, 8'h55);
    chk("R2 double key enters", 16'(cfg_mode), 16'h1);
    bus_rd(IDXP, v); chk("R12 index after reset", 16'(v), 16'h00);
    bus_rd(16'h03F4, v); chk("R1 other address in cfg", 16'(v), 16'hFF);

    // R5: 0x55 is latched as an index in config mode
    bus_wr(IDXP, 8'h55);
    bus_rd(IDXP, v); chk("R5 index 0x55 latched", 16'(v), 16'h55);

    // R6: global reset values
    for (int i = 0; i < 48; i++) begin
      reg_rd(8'(i), v);
      chk($sformatf("R6 glb reset %0h", i), 16'(v), 16'(exp_glb(i)));
    end

    // R3: exit key does not replace the index
    bus_wr(IDXP, 8'h21); bus_wr(IDXP, 8'hAA);
    chk("R3 exit key", 16'(cfg_mode), 16'h0);
    // R4: data write while locked is dropped
    bus_wr(DATP, 8'h99);
    bus_wr(IDXP, 8'h55); bus_wr(IDXP, 8'h55);
    bus_rd(IDXP, v); chk("R3 index kept over exit", 16'(v), 16'h21);
    bus_rd(DATP, v); chk("R4 locked data write ignored", 16'(v), 16'h01);

    // R7 / R8 / R10 / R9: every device selection
    for (int d = 0; d < 13; d++) begin
      logic ok, lk, vis;
      ok  = (d < 10) && wr_ok(d);
      lk  = (d < 10) && irq_lock(d);
      vis = d < 10;
      reg_wr(8'h07, 8'(d));
      reg_rd(8'h61, v);
      chk($sformatf("R9 base low read dev%0d", d), 16'(v),
          vis ? 16'(exp_base(d)) & 16'h00FF : 16'h0);
      reg_wr(8'h80, 8'hA0 + 8'(d));
      reg_rd(8'h80, v);
      chk($sformatf("R8 free index dev%0d", d), 16'(v), ok ? 16'(8'hA0 + 8'(d)) : 16'h0);
      reg_wr(8'h75, 8'h50 + 8'(d));
      reg_rd(8'h75, v);
      chk($sformatf("R8 irq range dev%0d", d), 16'(v),
          (ok && !lk) ? 16'(8'h50 + 8'(d)) : 16'h0);
      if (vis) begin
        bus_wr(IDXP, 8'h70); bus_wr(DATP, 8'h09);
        chk($sformatf("R10 irq strobe dev%0d", d), 16'(dev_update[d]), 16'(ok && !lk));
        chk($sformatf("R9 irq out dev%0d", d), 16'(dev_irq[8*d +: 8]),
            (ok && !lk) ? 16'h09 : 16'(exp_irq(d)));
        bus_wr(IDXP, 8'h30); bus_wr(DATP, 8'(wr_ok(d)));
        chk($sformatf("R10 same value no strobe dev%0d", d), 16'(dev_update), 16'h0);
        bus_wr(DATP, 8'h00);
        chk($sformatf("R10 activate strobe dev%0d", d), 16'(dev_update[d]), 16'(ok));
        @(negedge clk);
        chk($sformatf("R10 strobe one cycle dev%0d", d), 16'(dev_update), 16'h0);
        chk($sformatf("R9 active out dev%0d", d), 16'(dev_active[d]), 16'h0);
      end
    end

    // R9: base output follows a write to the high byte
    reg_wr(8'h07, 8'h04);
    reg_wr(8'h60, 8'h02);
    chk("R9 base out dev4", dev_base[64 +: 16], 16'h02F8);

    // R6: pattern sweep of the global bank (index 7 kept valid)
    for (int i = 0; i < 48; i++) reg_wr(8'(i), (i == 7) ? 8'h03 : 8'(i * 5) ^ 8'h5A);
    for (int i = 0; i < 48; i++) begin
      reg_rd(8'(i), v);
      chk($sformatf("R6 glb pattern %0h", i), 16'(v),
          (i == 7) ? 16'h03 : 16'(8'(i * 5) ^ 8'h5A));
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule